// File: doc/BRIEF.md
# Byte-Stream Packet Deframer and Write Transaction Parser

This block sits behind a serial byte receiver, such as an SPI slave shifter, and takes one byte for each cycle in which the valid strobe is high. Reserved marker bytes in the stream carry the packet boundaries and a channel number. The block removes these markers, undoes escaping, and presents the rebuilt packet as a symbol stream. Each symbol is tagged with start-of-packet, end-of-packet and channel.

A second stage reads the rebuilt packet as a memory-mapped transaction. The packet opens with an eight-byte header that gives a type, a byte count and a target address. When the type is a write, the data bytes that follow are packed into 32-bit words. Each word is issued on a request interface together with its address.

Framing problems, unknown transaction types and short packets raise sticky error flags. Only a reset clears these flags.

Top module: `stream_txn_deframer`

## Requirements
- R1: Byte 0x7A opens a packet and resets the channel to 0. The raw byte that follows a 0x7C marker becomes the channel of the packet. Literal bytes that arrive while no packet is open are ignored.
- R2: Byte 0x7B marks the next literal byte as the final byte of the packet. That byte is output with pkt_eop_o high. The first literal byte after 0x7A is output with pkt_sop_o high.
- R3: After byte 0x7D, the next byte is XORed with 0x20 and passed through as literal data. This lets the values 0x7A to 0x7D travel as payload, including as the final byte.
- R4: The header is 8 bytes, all most significant byte first: a type byte, a reserved byte, a 16-bit size in bytes, then a 32-bit address.
- R5: Types 0x00 and 0x04 are writes. Data bytes are packed with the first byte in bits 31:24. A word is issued with req_valid_o after every fourth byte. The first word goes to the header address and each later word to the previous address plus 4. req_last_o marks the word that completes the size. Bytes beyond the size are ignored.
- R6: Any other type value sets err_type_o. No request words are issued for that packet.
- R7: If a packet ends before its full header, or before the number of data bytes its size gives, err_len_o is set.
- R8: A 0x7A that arrives while a packet is open sets err_frame_o and discards the partial transaction. The new packet is then parsed from its first header byte.
- R9: All three error flags are sticky. An active-low asynchronous reset clears every flag and output and returns the block to waiting for a start marker.
- R10: A symbol appears on the pkt outputs one cycle after its byte is accepted. A request word appears one cycle after the symbol that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Input byte strobe |
| byte_i | input | 8 | Input byte |
| pkt_valid_o | output | 1 | Deframed symbol valid |
| pkt_data_o | output | 8 | Deframed symbol |
| pkt_sop_o | output | 1 | First symbol of packet |
| pkt_eop_o | output | 1 | Last symbol of packet |
| pkt_chan_o | output | 8 | Channel of packet |
| req_valid_o | output | 1 | Write word valid |
| req_addr_o | output | 32 | Write word address |
| req_data_o | output | 32 | Write word data |
| req_size_o | output | 16 | Size field of transaction |
| req_last_o | output | 1 | Word completes size |
| err_frame_o | output | 1 | Sticky framing error |
| err_type_o | output | 1 | Sticky unsupported type |
| err_len_o | output | 1 | Sticky length error |

## Verification
The first pattern is a clean 4-byte write with no escapes. It shows that marker stripping, header field order and the late end marker are handled, and it pins the one-cycle latency of each stage. A two-word write follows, with escaped marker values in its data and an escaped final byte. It separates escape handling from marker detection and shows address stepping and the last-word flag. Further packets cover an unsupported type, a short packet, and a start marker inside an open packet. These tell apart the three error flags and show that the following good packet recovers. Bytes sent with no packet open and a reset after errors show that stray input is ignored and that the flags clear only on reset.

// File: rtl/stream_txn_pkg.sv
package stream_txn_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned SIZE_W   = 16;
  localparam int unsigned WORD_B   = WORD_W / BYTE_W;
  localparam int unsigned FILL_W   = $clog2(WORD_B);
  localparam int unsigned HDR_B    = 2 + SIZE_W / BYTE_W + ADDR_W / BYTE_W;
  localparam int unsigned HIDX_W   = $clog2(HDR_B);

  localparam logic [7:0] MK_SOP  = 8'h7A;
  localparam logic [7:0] MK_EOP  = 8'h7B;
  localparam logic [7:0] MK_CHAN = 8'h7C;
  localparam logic [7:0] MK_ESC  = 8'h7D;
  localparam logic [7:0] ESC_XOR = 8'h20;

  localparam logic [7:0] TY_WR_A = 8'h00;
  localparam logic [7:0] TY_WR_B = 8'h04;

  typedef struct packed {
    logic              valid;
    logic [BYTE_W-1:0] data;
    logic              sop;
    logic              eop;
    logic [BYTE_W-1:0] chan;
  } sym_t;

  typedef enum logic [1:0] {P_IDLE, P_HDR, P_DATA, P_DROP} pstate_e;
endpackage

// File: rtl/stream_deframer.sv
module stream_deframer
  import stream_txn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output sym_t              sym_o,
  output logic              abort_o
);
  logic in_pkt_q, sop_pend_q, eop_pend_q, esc_pend_q, chan_pend_q;
  logic [BYTE_W-1:0] chan_q;

  logic take, is_mk, is_lit, emit;
  logic [BYTE_W-1:0] lit;

  always_comb begin
    take   = valid_i && !chan_pend_q;
    is_mk  = byte_i inside {MK_SOP, MK_EOP, MK_CHAN, MK_ESC};
    is_lit = take && (esc_pend_q || !is_mk);
    lit    = esc_pend_q ? (byte_i ^ ESC_XOR) : byte_i;
    emit   = is_lit && in_pkt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q    <= 1'b0;
      sop_pend_q  <= 1'b0;
      eop_pend_q  <= 1'b0;
      esc_pend_q  <= 1'b0;
      chan_pend_q <= 1'b0;
      chan_q      <= '0;
      sym_o       <= '0;
      abort_o     <= 1'b0;
    end else begin
      sym_o.valid <= 1'b0;
      abort_o     <= 1'b0;
      if (valid_i && chan_pend_q) begin
        chan_q      <= byte_i;
        chan_pend_q <= 1'b0;
      end else if (is_lit) begin
        esc_pend_q <= 1'b0;
        if (emit) begin
          sym_o.valid <= 1'b1;
          sym_o.data  <= lit;
          sym_o.sop   <= sop_pend_q;
          sym_o.eop   <= eop_pend_q;
          sym_o.chan  <= chan_q;
          sop_pend_q  <= 1'b0;
          if (eop_pend_q) begin
            in_pkt_q   <= 1'b0;
            eop_pend_q <= 1'b0;
          end
        end
      end else if (take) begin
        unique case (byte_i)
          MK_SOP: begin
            abort_o    <= in_pkt_q;
            in_pkt_q   <= 1'b1;
            sop_pend_q <= 1'b1;
            eop_pend_q <= 1'b0;
            chan_q     <= '0;
          end
          MK_EOP:  if (in_pkt_q) eop_pend_q <= 1'b1;
          MK_CHAN: chan_pend_q <= 1'b1;
          default: esc_pend_q <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/txn_parser.sv
module txn_parser
  import stream_txn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sym_t              sym_i,
  input  logic              abort_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [WORD_W-1:0] req_data_o,
  output logic [SIZE_W-1:0] req_size_o,
  output logic              req_last_o,
  output logic              err_frame_o,
  output logic              err_type_o,
  output logic              err_len_o
);
  pstate_e           st_q;
  logic [HIDX_W-1:0] idx_q;
  logic [7:0]        type_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] word_q;
  logic [FILL_W-1:0] fill_q;
  logic [SIZE_W:0]   cnt_q;

  logic              is_wr, room, full;
  logic [SIZE_W:0]   cnt_nx;
  logic [WORD_W-1:0] word_nx;

  always_comb begin
    is_wr   = (type_q == TY_WR_A) || (type_q == TY_WR_B);
    room    = cnt_q < {1'b0, size_q};
    cnt_nx  = cnt_q + {{SIZE_W{1'b0}}, room};
    word_nx = {word_q[WORD_W-BYTE_W-1:0], sym_i.data};
    full    = room && (fill_q == FILL_W'(WORD_B - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= P_IDLE;
      idx_q       <= '0;
      type_q      <= '0;
      size_q      <= '0;
      addr_q      <= '0;
      word_q      <= '0;
      fill_q      <= '0;
      cnt_q       <= '0;
      req_valid_o <= 1'b0;
      req_addr_o  <= '0;
      req_data_o  <= '0;
      req_size_o  <= '0;
      req_last_o  <= 1'b0;
      err_frame_o <= 1'b0;
      err_type_o  <= 1'b0;
      err_len_o   <= 1'b0;
    end else begin
      req_valid_o <= 1'b0;
      req_last_o  <= 1'b0;
      if (abort_i) begin
        err_frame_o <= 1'b1;
        st_q        <= P_IDLE;
      end else if (sym_i.valid && sym_i.sop) begin
        type_q <= sym_i.data;
        idx_q  <= HIDX_W'(1);
        if (sym_i.eop) begin
          err_len_o <= 1'b1;
          st_q      <= P_IDLE;
        end else begin
          st_q <= P_HDR;
        end
      end else if (sym_i.valid) begin
        unique case (st_q)
          P_HDR: begin
            idx_q <= idx_q + HIDX_W'(1);
            if (idx_q == HIDX_W'(2) || idx_q == HIDX_W'(3))
              size_q <= {size_q[SIZE_W-BYTE_W-1:0], sym_i.data};
            else if (idx_q >= HIDX_W'(4))
              addr_q <= {addr_q[ADDR_W-BYTE_W-1:0], sym_i.data};
            if (sym_i.eop) begin
              st_q <= P_IDLE;
              if (idx_q != HIDX_W'(HDR_B - 1) || size_q != '0) err_len_o <= 1'b1;
              if (idx_q == HIDX_W'(HDR_B - 1) && !is_wr) err_type_o <= 1'b1;
            end else if (idx_q == HIDX_W'(HDR_B - 1)) begin
              cnt_q  <= '0;
              fill_q <= '0;
              if (is_wr) st_q <= P_DATA;
              else begin
                st_q       <= P_DROP;
                err_type_o <= 1'b1;
              end
            end
          end
          P_DATA: begin
            if (room) begin
              word_q <= word_nx;
              fill_q <= fill_q + FILL_W'(1);
              cnt_q  <= cnt_nx;
            end
            if (full) begin
              req_valid_o <= 1'b1;
              req_data_o  <= word_nx;
              req_addr_o  <= addr_q;
              req_size_o  <= size_q;
              req_last_o  <= (cnt_nx == {1'b0, size_q});
              addr_q      <= addr_q + ADDR_W'(WORD_B);
            end
            if (sym_i.eop) begin
              st_q <= P_IDLE;
              if (cnt_nx < {1'b0, size_q}) err_len_o <= 1'b1;
            end
          end
          P_DROP: if (sym_i.eop) st_q <= P_IDLE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/stream_txn_deframer.sv
module stream_txn_deframer
  import stream_txn_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        pkt_valid_o,
  output logic [7:0]  pkt_data_o,
  output logic        pkt_sop_o,
  output logic        pkt_eop_o,
  output logic [7:0]  pkt_chan_o,
  output logic        req_valid_o,
  output logic [31:0] req_addr_o,
  output logic [31:0] req_data_o,
  output logic [15:0] req_size_o,
  output logic        req_last_o,
  output logic        err_frame_o,
  output logic        err_type_o,
  output logic        err_len_o
);
  sym_t sym;
  logic abort;

  stream_deframer u_deframer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (byte_valid_i),
    .byte_i  (byte_i),
    .sym_o   (sym),
    .abort_o (abort)
  );

  txn_parser u_parser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_i       (sym),
    .abort_i     (abort),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o),
    .req_data_o  (req_data_o),
    .req_size_o  (req_size_o),
    .req_last_o  (req_last_o),
    .err_frame_o (err_frame_o),
    .err_type_o  (err_type_o),
    .err_len_o   (err_len_o)
  );

  assign pkt_valid_o = sym.valid;
  assign pkt_data_o  = sym.data;
  assign pkt_sop_o   = sym.sop & sym.valid;
  assign pkt_eop_o   = sym.eop & sym.valid;
  assign pkt_chan_o  = sym.chan;
endmodule

// File: rtl/stream_txn_deframer_chk.sv
module stream_txn_deframer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pkt_valid_o,
  input logic pkt_sop_o,
  input logic pkt_eop_o,
  input logic req_valid_o,
  input logic req_last_o,
  input logic err_frame_o,
  input logic err_type_o,
  input logic err_len_o
);
  a_r10_word_follows_symbol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> $past(pkt_valid_o));
  a_r2_marks_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_sop_o || pkt_eop_o) |-> pkt_valid_o);
  a_r5_last_is_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_last_o |-> req_valid_o);
  a_r8_frame_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_frame_o |=> err_frame_o);
  a_r6_type_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_type_o |=> err_type_o);
  a_r7_len_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_len_o |=> err_len_o);
endmodule

bind stream_txn_deframer stream_txn_deframer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_valid_o (pkt_valid_o),
  .pkt_sop_o   (pkt_sop_o),
  .pkt_eop_o   (pkt_eop_o),
  .req_valid_o (req_valid_o),
  .req_last_o  (req_last_o),
  .err_frame_o (err_frame_o),
  .err_type_o  (err_type_o),
  .err_len_o   (err_len_o)
);

// File: tb/stream_txn_deframer_bench.sv
module stream_txn_deframer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        pkt_valid_o, pkt_sop_o, pkt_eop_o;
  logic [7:0]  pkt_data_o, pkt_chan_o;
  logic        req_valid_o, req_last_o;
  logic [31:0] req_addr_o, req_data_o;
  logic [15:0] req_size_o;
  logic        err_frame_o, err_type_o, err_len_o;

  int n_chk = 0;
  int n_bad = 0;

  stream_txn_deframer u_stream_txn_deframer (.*);

  always #2 clk_i = ~clk_i;

  int          n_req, n_sym, n_sop;
  logic [31:0] r_addr [8];
  logic [31:0] r_data [8];
  logic        r_last [8];
  logic [7:0]  eop_data, eop_chan, sop_data;

  always @(negedge clk_i) if (rst_ni) begin
    if (req_valid_o && n_req < 8) begin
      r_addr[n_req] = req_addr_o;
      r_data[n_req] = req_data_o;
      r_last[n_req] = req_last_o;
    end
    if (req_valid_o) n_req++;
    if (pkt_valid_o) begin
      n_sym++;
      if (pkt_sop_o) begin n_sop++; sop_data = pkt_data_o; end
      if (pkt_eop_o) begin eop_data = pkt_data_o; eop_chan = pkt_chan_o; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_req = 0; n_sym = 0; n_sop = 0;
    eop_data = '0; eop_chan = '0; sop_data = '0;
  endtask

  task automatic put(input logic [7:0] b);
    byte_i = b; byte_valid_i = 1'b1;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    clr();
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    idle(2);
    chk(!pkt_valid_o && !req_valid_o && !err_frame_o && !err_type_o && !err_len_o,
        "R9 reset state", {pkt_valid_o, req_valid_o, err_frame_o, err_type_o, err_len_o}, 0);
    rst_ni = 1'b1;
    idle(1);
    clr();
  endtask

  task automatic t_basic();
    logic [7:0] s [15] = '{8'h7A, 8'h7C, 8'h00, 8'h04, 8'h00, 8'h00, 8'h04, 8'h00,
                           8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h7B};
    clr();
    foreach (s[i]) put(s[i]);
    put(8'h01);
    chk(pkt_valid_o && pkt_eop_o && !req_valid_o, "R10 symbol one cycle, word not yet",
        {pkt_valid_o, pkt_eop_o, req_valid_o}, 3'b110);
    idle(1);
    chk(req_valid_o, "R10 word one cycle after symbol", req_valid_o, 1);
    idle(2);
    chk(n_sym == 12 && n_sop == 1 && sop_data == 8'h04, "R1 symbol count and first byte",
        {n_sym, sop_data}, {32'd12, 8'h04});
    chk(eop_data == 8'h01 && eop_chan == 8'h00, "R2 end marker tags following byte",
        {eop_data, eop_chan}, 16'h0100);
    chk(n_req == 1 && r_addr[0] == 32'h3C && r_data[0] == 32'h1 && r_last[0],
        "R4 R5 single word write", {r_addr[0], r_data[0]}, {32'h3C, 32'h1});
    chk(!err_frame_o && !err_type_o && !err_len_o, "R7 no errors on clean write",
        {err_frame_o, err_type_o, err_len_o}, 0);
  endtask

  task automatic t_escape();
    logic [7:0] s [28] = '{8'h7A, 8'h7C, 8'h05, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00,
                           8'h00, 8'h01, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44,
                           8'h7D, 8'h5A, 8'h7D, 8'h5B, 8'h7D, 8'h5C, 8'h7B, 8'h7D, 8'h5D,
                           8'h00, 8'h00, 8'h00, 8'h00};
    clr();
    for (int i = 0; i < 24; i++) put(s[i]);
    idle(3);
    chk(n_req == 2, "R5 two words issued", n_req, 2);
    chk(r_addr[0] == 32'h100 && r_data[0] == 32'h11223344 && !r_last[0],
        "R5 first word", {r_addr[0], r_data[0]}, {32'h100, 32'h11223344});
    chk(r_addr[1] == 32'h104 && r_data[1] == 32'h7A7B7C7D && r_last[1],
        "R3 escaped word and address step", {r_addr[1], r_data[1]}, {32'h104, 32'h7A7B7C7D});
    chk(eop_data == 8'h7D && eop_chan == 8'h05, "R3 escaped final byte, R1 channel",
        {eop_data, eop_chan}, 16'h7D05);
  endtask

  task automatic t_unsup();
    logic [7:0] s [11] = '{8'h7A, 8'h14, 8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 8'h00,
                           8'h10, 8'h7B, 8'hAA};
    do_reset();
    foreach (s[i]) put(s[i]);
    idle(3);
    chk(n_req == 0 && err_type_o && !err_len_o, "R6 unsupported type",
        {n_req, err_type_o}, {32'd0, 1'b1});
  endtask

  task automatic t_short();
    logic [7:0] s [14] = '{8'h7A, 8'h04, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 8'h02,
                           8'h00, 8'h01, 8'h02, 8'h03, 8'h7B, 8'h04};
    do_reset();
    foreach (s[i]) put(s[i]);
    idle(3);
    chk(n_req == 1 && r_data[0] == 32'h01020304 && !r_last[0] && r_addr[0] == 32'h200,
        "R5 partial packet word", r_data[0], 32'h01020304);
    chk(err_len_o && !err_type_o && !err_frame_o, "R7 short packet length error",
        {err_frame_o, err_type_o, err_len_o}, 3'b001);
    clr();
    put(8'h7A); put(8'h00); put(8'h00); put(8'h7B); put(8'h00);
    idle(3);
    chk(err_len_o && n_req == 0, "R9 length flag stays set", err_len_o, 1);
  endtask

  task automatic t_restart();
    logic [7:0] s [20] = '{8'h7A, 8'h04, 8'h00, 8'h00,
                           8'h7A, 8'h7C, 8'h02, 8'h04, 8'h00, 8'h00, 8'h04, 8'h00,
                           8'h00, 8'h00, 8'h40, 8'hDE, 8'hAD, 8'hBE, 8'h7B, 8'hEF};
    do_reset();
    foreach (s[i]) put(s[i]);
    idle(3);
    chk(err_frame_o, "R8 framing error on early start", err_frame_o, 1);
    chk(n_req == 1 && r_addr[0] == 32'h40 && r_data[0] == 32'hDEADBEEF && r_last[0],
        "R8 restarted packet parsed", {r_addr[0], r_data[0]}, {32'h40, 32'hDEADBEEF});
    chk(eop_chan == 8'h02 && !err_len_o, "R8 restart channel", eop_chan, 8'h02);
  endtask

  task automatic t_outside();
    do_reset();
    put(8'h11); put(8'h22); put(8'h7B); put(8'h33);
    idle(3);
    chk(n_sym == 0 && n_req == 0, "R1 bytes outside packet ignored", n_sym, 0);
  endtask

  task automatic t_clear();
    put(8'h7A); put(8'h7A);
    idle(2);
    chk(err_frame_o, "R8 back to back start", err_frame_o, 1);
    do_reset();
    chk(!err_frame_o && !err_type_o && !err_len_o, "R9 reset clears flags",
        {err_frame_o, err_type_o, err_len_o}, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_escape();
    t_unsup();
    t_short();
    t_restart();
    t_outside();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule